// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block is the software-facing register front end of an interrupt router. It shows only two 32-bit locations on a simple register bus. One is an 8-bit index-select register. The other is a data window whose meaning depends on the current select value. Through the window, software reaches three things: a 4-bit identifier, a read-only version word, and a table of 64-bit routing entries, one per input pin. Each entry is seen as two 32-bit halves. The even select value reaches the low half and the odd select value reaches the high half.

The block owns the select register, the identifier and the routing-table storage. The pin-servicing logic uses a combinational read port into the table. It also has a one-cycle strobe that marks an entry as in service (bit 14). A software write to the low half of an entry always clears that in-service bit.

When a low-half write changes the mask bit or the trigger-mode bit of an entry, a small notifier state machine emits a one-cycle pulse carrying the entry index. The notifier has two states, `NT_IDLE` and `NT_PULSE`. From either state, a qualifying write moves it to `NT_PULSE`; a cycle without one moves it to `NT_IDLE`. The pulse output is high exactly while the machine is in `NT_PULSE`.

Top module: `irw_window`

## Requirements
- R1: A write to bus offset 0x00 stores the low 8 bits of the write data as the select value. A read of offset 0x00 returns that value in bits 7:0, with zeros above.
- R2: With select 0x01, the window reads as NUM_PINS-1 in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits zero. Writes there change nothing.
- R3: With select 0x00, a window write stores data bits 27:24 as the identifier, and a read returns it in bits 27:24 with all other bits zero. Select 0x02 reads the same identifier, and writes with select 0x02 change nothing.
- R4: With select s >= 0x10, the window reaches entry (s-0x10)>>1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. A write to one half leaves the other half unchanged.
- R5: Select values 0x03 to 0x0F, and any select whose entry index is NUM_PINS or more, read as 0xFFFFFFFF through the window. Writes with such select values change no entry and no other state.
- R6: A low-half write stores the data with bit 14 (in service) forced to 0. A high-half write leaves bit 14 unchanged.
- R7: A one-cycle `svc_set_busy` strobe sets bit 14 of entry `svc_set_idx` at the next edge. If a low-half write to the same entry happens in the same cycle, the write wins and bit 14 ends at 0.
- R8: `svc_entry` shows entry `svc_idx` combinationally. An index of NUM_PINS or more shows all ones.
- R9: A low-half write that changes bit 16 (mask) or bit 15 (trigger mode, 1 = level) of an in-range entry makes `chg_valid` high for exactly the next cycle, with `chg_idx` equal to that entry index. Any other write leaves `chg_valid` low.
- R10: Bus offsets other than 0x00 and 0x10 read as 0, and writes to them are ignored.
- R11: After reset, every entry holds 0x0000_0000_0001_0000 (mask set), the select value and identifier are 0, and `chg_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from offset and state |
| svc_idx | input | IDX_W (5) | Servicing read-port entry index |
| svc_entry | output | 64 | Entry at `svc_idx` |
| svc_set_busy | input | 1 | Strobe: mark entry in service |
| svc_set_idx | input | IDX_W (5) | Entry to mark |
| chg_valid | output | 1 | One-cycle entry-change pulse |
| chg_idx | output | IDX_W (5) | Index of the changed entry |

## Verification
The bench builds the block with its defaults: 24 pins and version code 0x11. With 24 pins, the last valid entry sits at select values 0x3E/0x3F, and select 0x40 is the first index past the table. Both sides of that edge are reachable with ordinary 8-bit writes. The 5-bit service index can also name entries 24 to 31, so the all-ones rule on the read port can be exercised as well.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam int SEL_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ENTRY_W = 64;
    localparam int RIDX_W  = SEL_W - 1;

    localparam logic [SEL_W-1:0] ADDR_SEL = 8'h00;
    localparam logic [SEL_W-1:0] ADDR_WIN = 8'h10;
    localparam logic [SEL_W-1:0] SEL_BASE = 8'h10;

    localparam int BIT_RIRR = 14;
    localparam int BIT_TRIG = 15;
    localparam int BIT_MASK = 16;
    localparam int ID_LSB   = 24;
    localparam int ID_W     = 4;

    localparam logic [ENTRY_W-1:0] RESET_ENTRY = 64'h1 << BIT_MASK;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENTRY,
        TGT_BAD
    } tgt_e;

    typedef enum logic {
        NT_IDLE,
        NT_PULSE
    } nt_state_e;
endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [SEL_W-1:0]  sel,
    output tgt_e              tgt,
    output logic [RIDX_W-1:0] ridx,
    output logic              hi
);
    localparam logic [RIDX_W-1:0] NPINS_R = RIDX_W'(NUM_PINS);

    logic [SEL_W-1:0] off;
    assign off = sel - SEL_BASE;

    always_comb begin
        ridx = '0;
        hi   = sel[0];
        unique case (sel)
            8'h00:   tgt = TGT_ID;
            8'h01:   tgt = TGT_VER;
            8'h02:   tgt = TGT_ARB;
            default: begin
                if (sel >= SEL_BASE) begin
                    ridx = off[SEL_W-1:1];
                    tgt  = (off[SEL_W-1:1] < NPINS_R) ? TGT_ENTRY : TGT_BAD;
                end else begin
                    tgt = TGT_BAD;
                end
            end
        endcase
    end
endmodule

// File: rtl/irw_table.sv
module irw_table
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RIDX_W-1:0]   wr_ridx,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic [RIDX_W-1:0]   rd_ridx,
    output logic [ENTRY_W-1:0]  rd_entry,
    input  logic [IDX_W-1:0]    svc_idx,
    output logic [ENTRY_W-1:0]  svc_entry
);
    logic [ENTRY_W-1:0] ent_w [NUM_PINS];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
        logic [ENTRY_W-1:0] slot_q;
        logic               hit_w;
        logic               hit_s;

        assign hit_w = wr_en  && (wr_ridx == RIDX_W'(g));
        assign hit_s = set_en && (set_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= RESET_ENTRY;
            end else begin
                if (hit_s) begin
                    slot_q[BIT_RIRR] <= 1'b1;
                end
                if (hit_w) begin
                    if (wr_hi) begin
                        slot_q[ENTRY_W-1:DATA_W] <= wr_data;
                    end else begin
                        slot_q[DATA_W-1:0] <= wr_data;
                        slot_q[BIT_RIRR]   <= 1'b0;
                    end
                end
            end
        end

        assign ent_w[g] = slot_q;
    end

    always_comb begin
        rd_entry = '1;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_ridx == RIDX_W'(i)) rd_entry = ent_w[i];
        end
    end

    always_comb begin
        svc_entry = '1;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (svc_idx == IDX_W'(i)) svc_entry = ent_w[i];
        end
    end
endmodule

// File: rtl/irw_notify.sv
module irw_notify
    import irw_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [IDX_W-1:0] fire_idx,
    output logic             chg_valid,
    output logic [IDX_W-1:0] chg_idx
);
    nt_state_e        state_q;
    nt_state_e        state_d;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        unique case (state_q)
            NT_IDLE:  state_d = fire ? NT_PULSE : NT_IDLE;
            NT_PULSE: state_d = fire ? NT_PULSE : NT_IDLE;
            default:  state_d = NT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NT_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire) idx_q <= fire_idx;
        end
    end

    always_comb begin
        chg_valid = (state_q == NT_PULSE);
        chg_idx   = idx_q;
    end
endmodule

// File: rtl/irw_window.sv
module irw_window
    import irw_pkg::*;
#(
    parameter int              NUM_PINS     = 24,
    parameter logic [7:0]      VERSION_CODE = 8'h11,
    parameter int              IDX_W        = $clog2(NUM_PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]   svc_idx,
    output logic [ENTRY_W-1:0] svc_entry,
    input  logic               svc_set_busy,
    input  logic [IDX_W-1:0]   svc_set_idx,
    output logic               chg_valid,
    output logic [IDX_W-1:0]   chg_idx
);
    localparam logic [7:0] VER_PINS = 8'(NUM_PINS - 1);

    logic [SEL_W-1:0]   sel_q;
    logic [ID_W-1:0]    id_q;
    tgt_e               tgt;
    logic [RIDX_W-1:0]  ridx;
    logic               half_hi;
    logic [ENTRY_W-1:0] cur_entry;
    logic [DATA_W-1:0]  win_rdata;
    logic               win_wr;
    logic               tbl_wr;
    logic               fire;

    irw_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .sel  (sel_q),
        .tgt  (tgt),
        .ridx (ridx),
        .hi   (half_hi)
    );

    assign win_wr = bus_we && (bus_addr == ADDR_WIN);
    assign tbl_wr = win_wr && (tgt == TGT_ENTRY);

    irw_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr),
        .wr_ridx   (ridx),
        .wr_hi     (half_hi),
        .wr_data   (bus_wdata),
        .set_en    (svc_set_busy),
        .set_idx   (svc_set_idx),
        .rd_ridx   (ridx),
        .rd_entry  (cur_entry),
        .svc_idx   (svc_idx),
        .svc_entry (svc_entry)
    );

    // Only a low-half write can alter mask or trigger mode.
    assign fire = tbl_wr && !half_hi &&
                  ((cur_entry[BIT_MASK] != bus_wdata[BIT_MASK]) ||
                   (cur_entry[BIT_TRIG] != bus_wdata[BIT_TRIG]));

    irw_notify #(.IDX_W(IDX_W)) u_ntf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_idx  (ridx[IDX_W-1:0]),
        .chg_valid (chg_valid),
        .chg_idx   (chg_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (bus_we && (bus_addr == ADDR_SEL)) sel_q <= bus_wdata[SEL_W-1:0];
            if (win_wr && (tgt == TGT_ID))        id_q  <= bus_wdata[ID_LSB +: ID_W];
        end
    end

    always_comb begin
        unique case (tgt)
            TGT_ID, TGT_ARB: win_rdata = {4'h0, id_q, 24'h0};
            TGT_VER:         win_rdata = {8'h00, VER_PINS, 8'h00, VERSION_CODE};
            TGT_ENTRY:       win_rdata = half_hi ? cur_entry[ENTRY_W-1:DATA_W]
                                                 : cur_entry[DATA_W-1:0];
            default:         win_rdata = '1;
        endcase
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_SEL: bus_rdata = {24'h0, sel_q};
            ADDR_WIN: bus_rdata = win_rdata;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irw_window_chk.sv
module irw_window_chk #(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        sel_q,
    input logic [IDX_W-1:0]  svc_idx,
    input logic [63:0]       svc_entry,
    input logic              chg_valid
);
    logic [7:0] off;
    logic       oob;
    logic       lo_wr_here;

    assign off = sel_q - 8'h10;
    assign oob = ((sel_q >= 8'h03) && (sel_q < 8'h10)) ||
                 ((sel_q >= 8'h10) && ({1'b0, off[7:1]} >= 8'(NUM_PINS)));
    assign lo_wr_here = bus_we && (bus_addr == 8'h10) && (sel_q >= 8'h10) &&
                        !sel_q[0] && !oob && (off[7:1] == 7'(svc_idx));

    assert_sel_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h00) |=> (sel_q == $past(bus_wdata[7:0])));

    assert_version_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h10 && sel_q == 8'h01) |-> (bus_rdata[31:24] == 8'h00 && bus_rdata[15:8] == 8'h00 &&
                                                   bus_rdata[23:16] == 8'(NUM_PINS - 1)));

    assert_oob_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h10 && oob) |-> (bus_rdata == 32'hFFFF_FFFF));

    assert_rirr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_here |=> (!$stable(svc_idx) || !svc_entry[14]));

    assert_chg_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> $past(bus_we && bus_addr == 8'h10 && !oob && sel_q >= 8'h10));

    assert_other_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 8'h00 && bus_addr != 8'h10) |-> (bus_rdata == 32'h0));

    assert_reset_state_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (sel_q == 8'h00 && !chg_valid));
endmodule

bind irw_window irw_window_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sel_q     (sel_q),
    .svc_idx   (svc_idx),
    .svc_entry (svc_entry),
    .chg_valid (chg_valid)
);

// File: tb/irw_window_bench.sv
module irw_window_bench;
    localparam int NP = 24;
    localparam int IW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [IW-1:0] svc_idx = '0;
    logic [63:0] svc_entry;
    logic        svc_set_busy = 1'b0;
    logic [IW-1:0] svc_set_idx = '0;
    logic        chg_valid;
    logic [IW-1:0] chg_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irw_window u_irw_window (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .svc_idx(svc_idx),
        .svc_entry(svc_entry), .svc_set_busy(svc_set_busy),
        .svc_set_idx(svc_set_idx), .chg_valid(chg_valid), .chg_idx(chg_idx)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
        wr(8'h00, {24'h0, s});
        rd(8'h10, d);
    endtask

    task automatic svc_peek(input int idx, output logic [63:0] e);
        svc_idx = IW'(idx);
        #1 e = svc_entry;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [63:0] e;
        check("R11 chg_valid low", {63'h0, chg_valid}, 64'h0);
        rd(8'h00, d); check("R11 select zero", {32'h0, d}, 64'h0);
        rd(8'h10, d); check("R11 id zero", {32'h0, d}, 64'h0);
        svc_peek(0, e);  check("R11 entry0 reset", e, 64'h0000_0000_0001_0000);
        svc_peek(23, e); check("R11 entry23 reset", e, 64'h0000_0000_0001_0000);
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(8'h00, 32'hABCD_1234);
        rd(8'h00, d); check("R1 select low byte", {32'h0, d}, 64'h34);
    endtask

    task automatic t_version();
        logic [31:0] d;
        win_rd(8'h01, d); check("R2 version word", {32'h0, d}, 64'h0017_0011);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); check("R2 version write ignored", {32'h0, d}, 64'h0017_0011);
    endtask

    task automatic t_id();
        logic [31:0] d;
        wr(8'h00, 32'h0);
        wr(8'h10, 32'hF5FF_FFFF);
        rd(8'h10, d); check("R3 id stored", {32'h0, d}, 64'h0500_0000);
        win_rd(8'h02, d); check("R3 arb reads id", {32'h0, d}, 64'h0500_0000);
        wr(8'h10, 32'h0A00_0000);
        win_rd(8'h00, d); check("R3 arb write ignored", {32'h0, d}, 64'h0500_0000);
    endtask

    task automatic t_entry();
        logic [31:0] d; logic [63:0] e;
        wr(8'h00, 32'h16);
        wr(8'h10, 32'h0000_A031);
        check("R9 pulse on mask/trig change", {63'h0, chg_valid}, 64'h1);
        check("R9 pulse index", {59'h0, chg_idx}, 64'd3);
        @(negedge clk); #1;
        check("R9 pulse one cycle", {63'h0, chg_valid}, 64'h0);
        wr(8'h00, 32'h17);
        wr(8'h10, 32'h7700_0000);
        check("R9 high half no pulse", {63'h0, chg_valid}, 64'h0);
        rd(8'h10, d); check("R4 high half", {32'h0, d}, 64'h7700_0000);
        win_rd(8'h16, d); check("R4 low half", {32'h0, d}, 64'h0000_A031);
        svc_peek(3, e); check("R8 svc entry3", e, 64'h7700_0000_0000_A031);
        wr(8'h00, 32'h17);
        wr(8'h10, 32'h1200_0000);
        svc_peek(3, e); check("R4 high write keeps low", e, 64'h1200_0000_0000_A031);
    endtask

    task automatic t_oob();
        logic [31:0] d; logic [63:0] e;
        win_rd(8'h40, d); check("R5 index 24 ones", {32'h0, d}, 64'hFFFF_FFFF);
        wr(8'h10, 32'h0);
        check("R5 oob write no pulse", {63'h0, chg_valid}, 64'h0);
        win_rd(8'h3E, d); check("R5 index 23 in range", {32'h0, d}, 64'h0001_0000);
        win_rd(8'h0F, d); check("R5 gap select ones", {32'h0, d}, 64'hFFFF_FFFF);
        wr(8'h10, 32'h0);
        win_rd(8'hFF, d); check("R5 top select ones", {32'h0, d}, 64'hFFFF_FFFF);
        svc_peek(23, e); check("R5 entry23 untouched", e, 64'h0000_0000_0001_0000);
        svc_peek(0, e);  check("R5 entry0 untouched", e, 64'h0000_0000_0001_0000);
        svc_peek(24, e); check("R8 svc oob ones", e, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_rirr();
        logic [63:0] e;
        @(negedge clk); svc_set_busy = 1'b1; svc_set_idx = 5'd5;
        @(negedge clk); svc_set_busy = 1'b0;
        svc_peek(5, e); check("R7 set in service", e, 64'h0000_0000_0001_4000);
        wr(8'h00, 32'h1B);
        wr(8'h10, 32'h0000_00AA);
        svc_peek(5, e); check("R6 high write keeps bit14", e, 64'h0000_00AA_0001_4000);
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h0001_4042);
        check("R9 no change no pulse", {63'h0, chg_valid}, 64'h0);
        svc_peek(5, e); check("R6 low write clears bit14", e, 64'h0000_00AA_0001_0042);
    endtask

    task automatic t_collide();
        logic [63:0] e;
        wr(8'h00, 32'h1C);
        @(negedge clk);
        bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = 32'h0001_0007;
        svc_set_busy = 1'b1; svc_set_idx = 5'd6;
        @(negedge clk);
        bus_we = 1'b0; svc_set_busy = 1'b0;
        svc_peek(6, e); check("R7 low write beats set", e, 64'h0000_0000_0001_0007);
        wr(8'h00, 32'h1F);
        @(negedge clk);
        bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = 32'h5500_0000;
        svc_set_busy = 1'b1; svc_set_idx = 5'd7;
        @(negedge clk);
        bus_we = 1'b0; svc_set_busy = 1'b0;
        svc_peek(7, e); check("R7 set with high write", e, 64'h5500_0000_0001_4000);
    endtask

    task automatic t_change();
        wr(8'h00, 32'h22);
        wr(8'h10, 32'h0001_8000);
        check("R9 trig change pulse", {63'h0, chg_valid}, 64'h1);
        check("R9 trig change index", {59'h0, chg_idx}, 64'd9);
        wr(8'h10, 32'h0001_8055);
        check("R9 same bits no pulse", {63'h0, chg_valid}, 64'h0);
        wr(8'h10, 32'h0000_8055);
        check("R9 unmask pulse", {63'h0, chg_valid}, 64'h1);
    endtask

    task automatic t_other();
        logic [31:0] d;
        wr(8'h00, 32'h01);
        wr(8'h04, 32'hDEAD_BEEF);
        rd(8'h04, d); check("R10 other offset zero", {32'h0, d}, 64'h0);
        wr(8'h20, 32'h0000_0033);
        rd(8'h00, d); check("R10 select unchanged", {32'h0, d}, 64'h01);
        rd(8'h10, d); check("R10 window unchanged", {32'h0, d}, 64'h0017_0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_select();
        t_version();
        t_id();
        t_entry();
        t_oob();
        t_rirr();
        t_collide();
        t_change();
        t_other();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule